// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns a selectable clock-enable stream into CAN time quanta and then into bit periods. A 32-bit configuration word sets three things. It sets the prescaler divide value, the lengths of the two phase segments and the resynchronisation jump width, all in minus-one form. It also sets a 2-bit code that picks one of three clock-enable inputs. Each bit period starts with one synchronisation quantum. Phase segment 1 follows, and the block pulses `sample_stb` on its last quantum. Phase segment 2 comes last, and the block pulses `bit_stb` on its last quantum.

The block watches the received bus level at every quantum tick. A recessive-to-dominant transition seen in a phase segment shifts the bit period toward the transmitter's timing: it lengthens segment 1 or shortens segment 2 by the phase error, limited by the jump width. The configuration word is captured only while `halt` (reset mode) is high. While `halt` is high all counters are held idle. An invalid clock-select code also holds the counters idle and raises `cfg_err`.

All pins are plain control and status signals. The block carries no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `cbt_timing_gen`

## Requirements
- R1: Configuration fields sit in `cfg_word` as length minus one: segment 1 at bits 23:20 (lengths 4..16), prescaler at bits 17:8 (divide 1..1024), jump width at bits 5:4 (1..4), segment 2 at bits 2:0 (lengths 2..8), and clock select at bits 25:24.
- R2: The configuration is registered on each clock where `halt` is high. While `halt` is low, changes on `cfg_word` have no effect.
- R3: Clock select 0 uses `clk_en_p1`, 1 uses `clk_en_p2` and 3 uses `clk_en_ext`. `tq_tick` pulses on every (prescaler+1)-th cycle on which the selected enable is high, counting from a run start.
- R4: With clock select 2 the block raises `cfg_err`, emits no ticks or strobes, and holds its counters at their idle values.
- R5: With no edges a bit lasts 1 + TSEG1 + TSEG2 quanta. `seg_state` reads 0 in sync, 1 in segment 1 and 2 in segment 2. `sample_stb` pulses with the tick of the last segment-1 quantum and `bit_stb` with the tick of the last segment-2 quantum.
- R6: An edge seen at segment-1 quantum index q (counting from 0) extends segment 1 by min(q+1, jump width) quanta.
- R7: An edge seen at segment-2 quantum index q removes min(TSEG2−q, jump width) quanta from segment 2's original length. If the shortened end has already been reached, segment 2 ends on that quantum.
- R8: At most one resynchronisation is applied per bit. An edge seen during the sync quantum has no effect.
- R9: While reset or `halt` is active, `seg_state` is 0, the prescaler restarts from zero and no ticks or strobes are produced.
- R10: An edge is a `rx_bit` value of 0 at a tick after a value of 1 at the previous tick. After a run start the previous value is taken as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Reset mode: capture configuration, hold counters |
| cfg_word | input | 32 | Packed timing and clock-select configuration |
| clk_en_p1 | input | 1 | Clock enable, peripheral source 1 |
| clk_en_p2 | input | 1 | Clock enable, peripheral source 2 |
| clk_en_ext | input | 1 | Clock enable, external source |
| rx_bit | input | 1 | Received bus level (0 dominant) |
| tq_tick | output | 1 | One pulse per time quantum |
| sample_stb | output | 1 | Sample point strobe |
| bit_stb | output | 1 | End-of-bit strobe |
| seg_state | output | 2 | Current segment: 0 sync, 1 phase 1, 2 phase 2 |
| cfg_err | output | 1 | Clock-select code 2 is loaded |

## Verification
The assertions take for granted that the loaded segment lengths and the jump width stay within the legal ranges of R1, and that `cfg_word` is changed by the user only while `halt` is high. The stimulus follows both rules whenever it expects normal timing. It writes a different configuration during a run only to show that the write is ignored. The received level toggles at random hold times, so edges land in every segment and at every quantum index, including the boundary lengths and the jump width of 1.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int TS1_W  = 4;
  localparam int BRP_W  = 10;
  localparam int SJW_W  = 2;
  localparam int TS2_W  = 3;
  localparam int CSEL_W = 2;

  // bit positions inside the configuration word
  localparam int TS1_LSB  = 20;
  localparam int BRP_LSB  = 8;
  localparam int SJW_LSB  = 4;
  localparam int TS2_LSB  = 0;
  localparam int CSEL_LSB = 24;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_e;

  typedef enum logic [CSEL_W-1:0] {
    SRC_P1  = 2'd0,
    SRC_P2  = 2'd1,
    SRC_BAD = 2'd2,
    SRC_EXT = 2'd3
  } src_e;

  typedef struct packed {
    src_e             csel;
    logic [TS1_W-1:0] ts1_m1;
    logic [BRP_W-1:0] brp_m1;
    logic [SJW_W-1:0] sjw_m1;
    logic [TS2_W-1:0] ts2_m1;
  } cfg_t;
endpackage

// File: rtl/cbt_cfg_reg.sv
module cbt_cfg_reg
  import cbt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        halt,
  input  logic [31:0] cfg_word,
  input  logic        en_p1,
  input  logic        en_p2,
  input  logic        en_ext,
  output cfg_t        cfg,
  output logic        src_en,
  output logic        cfg_err
);
  cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (halt) begin
      cfg_q.csel   <= src_e'(cfg_word[CSEL_LSB +: CSEL_W]);
      cfg_q.ts1_m1 <= cfg_word[TS1_LSB +: TS1_W];
      cfg_q.brp_m1 <= cfg_word[BRP_LSB +: BRP_W];
      cfg_q.sjw_m1 <= cfg_word[SJW_LSB +: SJW_W];
      cfg_q.ts2_m1 <= cfg_word[TS2_LSB +: TS2_W];
    end
  end

  always_comb begin
    unique case (cfg_q.csel)
      SRC_P1:  src_en = en_p1;
      SRC_P2:  src_en = en_p2;
      SRC_EXT: src_en = en_ext;
      default: src_en = 1'b0;
    endcase
  end

  assign cfg_err = (cfg_q.csel == SRC_BAD);
  assign cfg     = cfg_q;
endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
  parameter int W = cbt_pkg::BRP_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         src_en,
  input  logic [W-1:0] div_m1,
  output logic         tq
);
  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap = (cnt_q == div_m1);
  assign tq   = run && src_en && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (src_en)  cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/cbt_seg_ctrl.sv
module cbt_seg_ctrl
  import cbt_pkg::*;
#(
  parameter int T1W = TS1_W,
  parameter int T2W = TS2_W,
  parameter int SJW = SJW_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           tq,
  input  logic           rx_bit,
  input  logic [T1W-1:0] ts1_m1,
  input  logic [T2W-1:0] ts2_m1,
  input  logic [SJW-1:0] sjw_m1,
  output seg_e           seg,
  output logic           sample_stb,
  output logic           bit_stb
);
  localparam int QW = T1W + 1;  // holds TSEG1 plus the largest jump
  localparam int QX = QW + 1;   // headroom for intermediate sums

  seg_e          seg_q;
  logic [QW-1:0] q_q, tgt_q;
  logic          done_q, rxp_q;

  logic [QX-1:0] q_x, ts1_x, ts2_x, sjw_x;
  logic [QX-1:0] lag, lead, cut1, cut2, tgt1, tgt2, tgt_x, tgt_eff;
  logic          edge_hit, seg_end;

  always_comb begin
    q_x   = QX'(q_q);
    ts1_x = QX'(ts1_m1);
    ts2_x = QX'(ts2_m1);
    sjw_x = QX'(sjw_m1) + QX'(1);
    tgt_x = QX'(tgt_q);
    // late edge in phase 1: error is quanta elapsed since the sync quantum
    lag   = q_x + QX'(1);
    cut1  = (lag < sjw_x) ? lag : sjw_x;
    tgt1  = ts1_x + cut1;
    // early edge in phase 2: error is quanta left in the segment
    lead  = ts2_x + QX'(1) - q_x;
    cut2  = (lead < sjw_x) ? lead : sjw_x;
    tgt2  = (ts2_x >= cut2) ? (ts2_x - cut2) : '0;
  end

  assign edge_hit = tq && rxp_q && !rx_bit && !done_q && (seg_q != SEG_SYNC);

  always_comb begin
    if (edge_hit) tgt_eff = (seg_q == SEG_PH1) ? tgt1 : tgt2;
    else          tgt_eff = tgt_x;
  end

  assign seg_end    = tq && (q_x >= tgt_eff);
  assign sample_stb = seg_end && (seg_q == SEG_PH1);
  assign bit_stb    = seg_end && (seg_q == SEG_PH2);
  assign seg        = seg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= SEG_SYNC;
      q_q    <= '0;
      tgt_q  <= '0;
      done_q <= 1'b0;
      rxp_q  <= 1'b1;
    end else if (!run) begin
      seg_q  <= SEG_SYNC;
      q_q    <= '0;
      tgt_q  <= '0;
      done_q <= 1'b0;
      rxp_q  <= 1'b1;
    end else if (tq) begin
      rxp_q <= rx_bit;
      unique case (seg_q)
        SEG_SYNC: begin
          seg_q <= SEG_PH1;
          q_q   <= '0;
          tgt_q <= QW'(ts1_x);
        end
        SEG_PH1: begin
          if (seg_end) begin
            seg_q <= SEG_PH2;
            q_q   <= '0;
            tgt_q <= QW'(ts2_x);
          end else begin
            q_q   <= q_q + 1'b1;
            tgt_q <= QW'(tgt_eff);
            if (edge_hit) done_q <= 1'b1;
          end
        end
        default: begin
          if (seg_end) begin
            seg_q  <= SEG_SYNC;
            q_q    <= '0;
            done_q <= 1'b0;
          end else begin
            q_q   <= q_q + 1'b1;
            tgt_q <= QW'(tgt_eff);
            if (edge_hit) done_q <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cbt_timing_gen.sv
module cbt_timing_gen
  import cbt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        halt,
  input  logic [31:0] cfg_word,
  input  logic        clk_en_p1,
  input  logic        clk_en_p2,
  input  logic        clk_en_ext,
  input  logic        rx_bit,
  output logic        tq_tick,
  output logic        sample_stb,
  output logic        bit_stb,
  output logic [1:0]  seg_state,
  output logic        cfg_err
);
  cfg_t cfg;
  logic src_en, run;
  seg_e seg;

  cbt_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .halt(halt), .cfg_word(cfg_word),
    .en_p1(clk_en_p1), .en_p2(clk_en_p2), .en_ext(clk_en_ext),
    .cfg(cfg), .src_en(src_en), .cfg_err(cfg_err)
  );

  assign run = !halt && !cfg_err;

  cbt_prescaler #(.W(BRP_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .src_en(src_en),
    .div_m1(cfg.brp_m1), .tq(tq_tick)
  );

  cbt_seg_ctrl #(.T1W(TS1_W), .T2W(TS2_W), .SJW(SJW_W)) u_seg (
    .clk(clk), .rst_n(rst_n), .run(run), .tq(tq_tick), .rx_bit(rx_bit),
    .ts1_m1(cfg.ts1_m1), .ts2_m1(cfg.ts2_m1), .sjw_m1(cfg.sjw_m1),
    .seg(seg), .sample_stb(sample_stb), .bit_stb(bit_stb)
  );

  assign seg_state = seg;
endmodule

// File: rtl/cbt_timing_gen_chk.sv
module cbt_timing_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       halt,
  input logic       tq_tick,
  input logic       sample_stb,
  input logic       bit_stb,
  input logic [1:0] seg_state,
  input logic       cfg_err
);
  assert_sample_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> tq_tick);
  assert_bit_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> tq_tick);
  assert_sample_then_ph2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> (seg_state == 2'd2));
  assert_bit_then_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> (seg_state == 2'd0));
  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sample_stb, bit_stb}) <= 1);
  assert_err_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !tq_tick);
  assert_halt_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (seg_state == 2'd0));
  assert_halt_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !tq_tick);
  assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(halt) |-> $stable(cfg_err));
endmodule

bind cbt_timing_gen cbt_timing_gen_chk i_chk (
  .clk(clk), .rst_n(rst_n), .halt(halt), .tq_tick(tq_tick),
  .sample_stb(sample_stb), .bit_stb(bit_stb), .seg_state(seg_state),
  .cfg_err(cfg_err)
);

// File: tb/test_cbt_timing_gen.sv
`timescale 1ns/1ps
module test_cbt_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt = 1'b1;
  logic [31:0] cfg_word = '0;
  logic        clk_en_p1 = 1'b0, clk_en_p2 = 1'b0, clk_en_ext = 1'b0;
  logic        rx_bit = 1'b1;
  logic        tq_tick, sample_stb, bit_stb, cfg_err;
  logic [1:0]  seg_state;

  always #2 clk = ~clk;  // 250 MHz

  cbt_timing_gen i_cbt_timing_gen (
    .clk(clk), .rst_n(rst_n), .halt(halt), .cfg_word(cfg_word),
    .clk_en_p1(clk_en_p1), .clk_en_p2(clk_en_p2), .clk_en_ext(clk_en_ext),
    .rx_bit(rx_bit), .tq_tick(tq_tick), .sample_stb(sample_stb),
    .bit_stb(bit_stb), .seg_state(seg_state), .cfg_err(cfg_err)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  string req = "R9";

  // behavioural reference state
  int m_cfg = 0, m_pcnt = 0, m_seg = 0, m_q = 0, m_tgt = 0;
  bit m_done = 0, m_rxp = 1;
  // expected values for the current cycle
  bit e_tq, e_smp, e_bit, e_err, e_run, e_en;
  int e_te;

  function automatic int mn(int a, int b); return (a < b) ? a : b; endfunction

  function automatic int cfgw(int csel, int ts1, int brp, int sjw, int ts2);
    return (csel << 24) | ((ts1 - 1) << 20) | ((brp - 1) << 8) | ((sjw - 1) << 4) | (ts2 - 1);
  endfunction

  task automatic model_eval();
    int code, ts1, ts2, sjw, brp, c;
    bit hit;
    code = (m_cfg >> 24) & 3; ts1 = (m_cfg >> 20) & 15; brp = (m_cfg >> 8) & 1023;
    sjw = ((m_cfg >> 4) & 3) + 1; ts2 = m_cfg & 7;
    e_err = (code == 2);
    e_en  = (code == 0) ? clk_en_p1 : (code == 1) ? clk_en_p2 : (code == 3) ? clk_en_ext : 1'b0;
    e_run = !halt && !e_err;
    e_tq  = e_run && e_en && (m_pcnt == brp);
    hit   = e_tq && m_rxp && !rx_bit && !m_done && (m_seg != 0);
    e_te  = m_tgt;
    if (hit && m_seg == 1) e_te = ts1 + mn(m_q + 1, sjw);
    if (hit && m_seg == 2) begin
      c = mn(ts2 + 1 - m_q, sjw);
      e_te = (ts2 >= c) ? ts2 - c : 0;
    end
    e_smp = e_tq && m_seg == 1 && m_q >= e_te;
    e_bit = e_tq && m_seg == 2 && m_q >= e_te;
    if (hit && !e_smp && !e_bit) m_done = m_done; // done set in step
  endtask

  task automatic model_step(input bit rstn, input bit hlt, input int word, input bit rx);
    int ts1, ts2, brp;
    bit hit;
    ts1 = (m_cfg >> 20) & 15; brp = (m_cfg >> 8) & 1023; ts2 = m_cfg & 7;
    hit = e_tq && m_rxp && !rx && !m_done && (m_seg != 0);
    if (!rstn) begin
      m_cfg = 0; m_pcnt = 0; m_seg = 0; m_q = 0; m_tgt = 0; m_done = 0; m_rxp = 1;
      return;
    end
    if (!e_run) begin
      m_pcnt = 0; m_seg = 0; m_q = 0; m_tgt = 0; m_done = 0; m_rxp = 1;
    end else begin
      if (e_en) m_pcnt = (m_pcnt == brp) ? 0 : m_pcnt + 1;
      if (e_tq) begin
        m_rxp = rx;
        if (m_seg == 0) begin m_seg = 1; m_q = 0; m_tgt = ts1; end
        else if (e_smp) begin m_seg = 2; m_q = 0; m_tgt = ts2; end
        else if (e_bit) begin m_seg = 0; m_q = 0; m_done = 0; end
        else begin m_q++; m_tgt = e_te; if (hit) m_done = 1; end
      end
    end
    if (hlt) m_cfg = word & 32'h03F3_FF37;
  endtask

  task automatic check(input bit ok, input string r, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", r, what, act, exp, $time);
    end
  endtask

  int last_bit = -1, cyc = 0, bit_gap = -1;

  // one clock: inputs already set after the falling edge
  task automatic cycle();
    bit r; bit h; int w; bit x;
    #1;
    model_eval();
    check(tq_tick == e_tq, "R3", "tq_tick", tq_tick, e_tq);
    check(sample_stb == e_smp, "R5", "sample_stb", sample_stb, e_smp);
    check(bit_stb == e_bit, (req == "R7" || req == "R6") ? req : "R5", "bit_stb", bit_stb, e_bit);
    check(seg_state == 2'(m_seg), req, "seg_state", seg_state, m_seg);
    check(cfg_err == e_err, "R4", "cfg_err", cfg_err, e_err);
    if (bit_stb) begin
      if (last_bit >= 0) bit_gap = cyc - last_bit;
      last_bit = cyc;
    end
    r = rst_n; h = halt; w = cfg_word; x = rx_bit;
    @(posedge clk);
    model_step(r, h, w, x);
    cyc++;
    @(negedge clk);
  endtask

  int hold = 0;
  task automatic run_random(input int n, input int p1_pct, input int p2_pct, input int ext_pct, input int max_hold);
    for (int i = 0; i < n; i++) begin
      clk_en_p1  = ($urandom_range(99) < p1_pct);
      clk_en_p2  = ($urandom_range(99) < p2_pct);
      clk_en_ext = ($urandom_range(99) < ext_pct);
      if (hold == 0) begin
        rx_bit = ~rx_bit;
        hold = $urandom_range(max_hold, 1);
      end else hold--;
      cycle();
    end
  endtask

  task automatic load_cfg(input int w);
    halt = 1'b1; cfg_word = w; cycle(); cycle();
    halt = 1'b0; rx_bit = 1'b1; hold = 3;
  endtask

  initial begin
    @(negedge clk);
    // R9: reset state
    repeat (4) cycle();
    rst_n = 1'b1;
    cycle();
    check(seg_state == 2'd0 && !tq_tick && !bit_stb, "R9", "reset idle", seg_state, 0);

    // R1/R5: field decode and nominal bit length: brp 3, seg1 5, seg2 3 => 27 cycles
    req = "R1";
    load_cfg(cfgw(0, 5, 3, 2, 3));
    clk_en_p1 = 1'b1; rx_bit = 1'b1;
    repeat (100) cycle();
    check(bit_gap == 27, "R1", "bit period cycles", bit_gap, 27);

    // R6/R7/R8/R10: random bus edges with a dense source
    req = "R6";
    run_random(2000, 100, 0, 0, 30);
    req = "R7";
    load_cfg(cfgw(0, 7, 2, 4, 8));
    run_random(2000, 80, 30, 30, 25);

    // R3: second peripheral source, sparse enables
    req = "R3";
    load_cfg(cfgw(1, 6, 4, 3, 4));
    run_random(1500, 90, 50, 90, 40);

    // R3/R8: external source at the largest segments, prescaler 1
    req = "R8";
    load_cfg(cfgw(3, 16, 1, 4, 8));
    run_random(1500, 0, 0, 70, 35);

    // R10: shortest legal segments, jump width 1
    req = "R10";
    load_cfg(cfgw(0, 4, 1, 1, 2));
    run_random(1500, 100, 0, 0, 12);

    // R2: writes while running are ignored
    req = "R2";
    cfg_word = cfgw(2, 9, 9, 1, 5);
    run_random(200, 100, 0, 0, 20);
    check(cfg_err == 1'b0, "R2", "cfg_err after write in run", cfg_err, 0);

    // R4: invalid clock select holds the block
    req = "R4";
    load_cfg(cfgw(2, 5, 2, 2, 3));
    run_random(150, 100, 100, 100, 10);
    check(cfg_err == 1'b1 && seg_state == 2'd0, "R4", "cfg_err with code 2", cfg_err, 1);

    // R9: halt in the middle of a run
    req = "R9";
    load_cfg(cfgw(0, 5, 2, 2, 3));
    run_random(300, 100, 0, 0, 20);
    halt = 1'b1;
    run_random(60, 100, 100, 100, 8);
    check(seg_state == 2'd0 && !tq_tick, "R9", "halted idle", seg_state, 0);
    halt = 1'b0;
    run_random(300, 100, 0, 0, 20);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired in %s actual=0 expected=1", req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule